// File: doc/BRIEF.md
# PHY Management Register File

This block holds the 32 management registers of a gigabit Ethernet PHY, each 16 bits wide. A management controller, for example an MDIO front end, reaches them through a plain read/write port. Every address is either read-write, read-only or unimplemented. The block checks each access against that capability. It loads fixed power-up values, enforces the write rules of the basic control register, and models auto-negotiation as a countdown whose success depends on a link-up input.

A read is presented for one cycle and its data comes back one cycle later, together with a valid strobe. A write takes effect at the clock edge that accepts it. An access that breaks the capability rules produces a one-cycle error strobe, one cycle after the request. A restart of auto-negotiation clears the completion and link bits in the status register and starts a countdown of `AN_CYCLES` clocks. When the countdown runs out and the link input is high, both bits are set again.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset the registers read as follows. Control (0): 0x1140. Status (1): 0x794D. Identifier 1 (2): 0x0141. Identifier 2 (3): the `PHY_ID2` parameter. Advertisement (4): 0x0DE1. Partner ability (5): 0x01E0. Expansion (6): 0x0000. 1000BASE-T control (9): 0x0E00. 1000BASE-T status (10): 0x3C00. Vendor control (16): 0x0360. Vendor status (17): 0xAC00. Extended control (20): 0x0D60. Receive error count (21): 0x0000.
- R2: A read request with `rd_en` high at a clock edge produces `rsp_valid` high, with the data on `rsp_rdata`, for exactly the following cycle. At all other times `rsp_valid` is low.
- R3: A write to a read-write address (4, 9, 16, 20) stores all 16 bits of `wdata`.
- R4: A write to the control register (address 0) stores the value with bits 15 (reset), 9 (restart auto-negotiation) and 5:0 forced to zero. Those bits always read back as zero.
- R5: A write to a read-only address (1, 2, 3, 5, 6, 10, 17, 21) or to an unimplemented address leaves the register file unchanged and raises `acc_err` for the following cycle. A write to a read-write address does not raise `acc_err`.
- R6: A read of an unimplemented address returns 0 and raises `acc_err` in the response cycle. A read of an implemented address does not raise `acc_err`.
- R7: A control write in which both bit 9 and bit 12 (auto-negotiation enable) are set restarts auto-negotiation. It clears status bit 5 (auto-negotiation complete) and status bit 2 (link up), and starts an `AN_CYCLES` countdown. A new restart during a countdown starts it again from the beginning.
- R8: A control write with bit 9 set and bit 12 clear starts no countdown and leaves the status register unchanged.
- R9: When the countdown expires while `link_in` is high, status bits 5 and 2 are set.
- R10: While `link_in` is low, status bits 5 and 2 are held clear, and a countdown that expires sets neither bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_in | input | 1 | Line link indication, synchronous to clk |
| wr_en | input | 1 | Write request strobe |
| rd_en | input | 1 | Read request strobe |
| addr | input | 5 | Register address for the request |
| wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after rd_en |
| rsp_rdata | output | 16 | Read data |
| acc_err | output | 1 | Access violation strobe, one cycle after the request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, and that `link_in` is already synchronous to `clk`. The bench drives every request on a falling edge, keeps it for exactly one cycle, and issues reads and writes only through separate tasks, so the two strobes never overlap. The bench changes `link_in` only on a falling edge, and only between requests.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 1 << ADDR_W;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_RO   = 2'd1,
    CAP_RW   = 2'd3
  } cap_e;

  // Register addresses that the management controller decodes
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_ID_HI  = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_ID_LO  = 5'd3;
  localparam logic [ADDR_W-1:0] ADR_ADV    = 5'd4;
  localparam logic [ADDR_W-1:0] ADR_PARTNER= 5'd5;
  localparam logic [ADDR_W-1:0] ADR_EXPN   = 5'd6;
  localparam logic [ADDR_W-1:0] ADR_GIG_CT = 5'd9;
  localparam logic [ADDR_W-1:0] ADR_GIG_ST = 5'd10;
  localparam logic [ADDR_W-1:0] ADR_VND_CT = 5'd16;
  localparam logic [ADDR_W-1:0] ADR_VND_ST = 5'd17;
  localparam logic [ADDR_W-1:0] ADR_EXT_CT = 5'd20;
  localparam logic [ADDR_W-1:0] ADR_RXERR  = 5'd21;

  // Control and status bit positions
  localparam int CTL_SOFT_RST = 15;
  localparam int CTL_AN_EN    = 12;
  localparam int CTL_AN_RERUN = 9;
  localparam int STS_AN_DONE  = 5;
  localparam int STS_LINK     = 2;

  localparam logic [DATA_W-1:0] CTL_DROP_MASK =
    (DATA_W'(1) << CTL_SOFT_RST) | (DATA_W'(1) << CTL_AN_RERUN) | DATA_W'(16'h003F);
  localparam logic [DATA_W-1:0] STS_AN_MASK =
    (DATA_W'(1) << STS_AN_DONE) | (DATA_W'(1) << STS_LINK);

  function automatic cap_e cap_of(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_CTRL, ADR_ADV, ADR_GIG_CT, ADR_VND_CT, ADR_EXT_CT: cap_of = CAP_RW;
      ADR_STAT, ADR_ID_HI, ADR_ID_LO, ADR_PARTNER, ADR_EXPN,
      ADR_GIG_ST, ADR_VND_ST, ADR_RXERR:                     cap_of = CAP_RO;
      default:                                               cap_of = CAP_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] id_lo);
    case (a)
      ADR_CTRL:    reset_val = 16'h1140;  // 1000 Mb/s, full duplex, AN enabled
      ADR_STAT:    reset_val = 16'h794D;  // link up, AN capable, ext caps; AN not done
      ADR_ID_HI:   reset_val = 16'h0141;
      ADR_ID_LO:   reset_val = id_lo;
      ADR_ADV:     reset_val = 16'h0DE1;
      ADR_PARTNER: reset_val = 16'h01E0;
      ADR_GIG_CT:  reset_val = 16'h0E00;
      ADR_GIG_ST:  reset_val = 16'h3C00;
      ADR_VND_CT:  reset_val = 16'h0360;
      ADR_VND_ST:  reset_val = 16'hAC00;
      ADR_EXT_CT:  reset_val = 16'h0D60;
      default:     reset_val = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_filter(input logic [DATA_W-1:0] v);
    ctrl_filter = v & ~CTL_DROP_MASK;
  endfunction

  function automatic logic rerun_request(input logic [DATA_W-1:0] v);
    rerun_request = v[CTL_AN_RERUN] & v[CTL_AN_EN];
  endfunction

endpackage

// File: rtl/phy_access_check.sv
module phy_access_check
  import phy_mgmt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output cap_e              cap,
  output logic              wr_ok,
  output logic              viol
);
  always_comb begin
    cap   = cap_of(addr);
    wr_ok = wr_en && (cap == CAP_RW);
    viol  = (wr_en && (cap != CAP_RW)) || (rd_en && (cap == CAP_NONE));
  end
endmodule

// File: rtl/phy_an_timer.sv
module phy_an_timer #(
  parameter int AN_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(AN_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(AN_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0) && !start;

  // R7: the countdown never holds a value beyond its length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) < AN_CYCLES));

  // R7: a restart always leaves the timer running on the next cycle
  a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int                 AN_CYCLES = 1000,
  parameter logic [DATA_W-1:0]  PHY_ID2   = 16'h0C20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              acc_err
);
  cap_e        req_cap;
  logic        wr_ok;
  logic        viol;
  logic        an_restart;
  logic        an_busy;
  logic        an_done;
  logic [DATA_W-1:0] regs [NUM_REGS];

  phy_access_check u_chk (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .cap   (req_cap),
    .wr_ok (wr_ok),
    .viol  (viol)
  );

  assign an_restart = wr_ok && (addr == ADR_CTRL) && rerun_request(wdata);

  phy_an_timer #(.AN_CYCLES(AN_CYCLES)) u_an (
    .clk   (clk),
    .rst_n (rst_n),
    .start (an_restart),
    .busy  (an_busy),
    .done  (an_done)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] A   = ADDR_W'(i);
    localparam cap_e              CAP = cap_of(A);
    logic [DATA_W-1:0] q;

    if (CAP == CAP_NONE) begin : g_none
      assign q = '0;
    end else if (A == ADR_STAT) begin : g_stat
      always_ff @(posedge clk) begin
        if (!rst_n)          q <= reset_val(A, PHY_ID2);
        else if (!link_in)   q <= q & ~STS_AN_MASK;
        else if (an_restart) q <= q & ~STS_AN_MASK;
        else if (an_done)    q <= q | STS_AN_MASK;
      end
    end else if (CAP == CAP_RO) begin : g_ro
      assign q = reset_val(A, PHY_ID2);
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)
          q <= reset_val(A, PHY_ID2);
        else if (wr_ok && (addr == A))
          q <= (A == ADR_CTRL) ? ctrl_filter(wdata) : wdata;
      end
    end

    assign regs[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? regs[addr] : '0;
      acc_err   <= viol;
    end
  end

  // R2: a response follows every read request
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);

  // R4: control reads never show the dropped bits
  a_r4_ctrl_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(addr) == ADR_CTRL) |-> ((rsp_rdata & CTL_DROP_MASK) == '0));

  // R5: a write outside the read-write set is flagged
  a_r5_bad_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_cap != CAP_RW) |=> acc_err);

  // R5: a write to identifier 1 never changes it
  a_r5_ro_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_ID_HI) |=> $stable(regs[ADR_ID_HI]));

  // R6: unimplemented reads return zero with an error
  a_r6_hole_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_cap == CAP_NONE) |=> (rsp_rdata == '0 && acc_err));

  // R7: a restart clears completion and link
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart |=> ((regs[ADR_STAT] & STS_AN_MASK) == '0));

  // R8: a rerun request without enable leaves an idle timer idle
  a_r8_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_CTRL && wdata[CTL_AN_RERUN] && !wdata[CTL_AN_EN] && !an_busy)
      |=> !an_busy);

  // R9: expiry with link up sets both bits
  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && link_in) |=> ((regs[ADR_STAT] & STS_AN_MASK) == STS_AN_MASK));

  // R10: link low keeps both bits clear
  a_r10_link_low: assert property (@(posedge clk) disable iff (!rst_n)
    !link_in |=> ((regs[ADR_STAT] & STS_AN_MASK) == '0));
endmodule

// File: tb/phy_mgmt_regfile_test.sv
module phy_mgmt_regfile_test;
  localparam int          AN_CYC = 20;
  localparam logic [15:0] ID2    = 16'h0C20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_in = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        acc_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 0;

  typedef struct {
    logic [15:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  phy_mgmt_regfile #(.AN_CYCLES(AN_CYC), .PHY_ID2(ID2)) uut (
    .clk(clk), .rst_n(rst_n), .link_in(link_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .acc_err(acc_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops one expected item for every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_rdata == e.d, {e.tag, " data"}, 32'(rsp_rdata), 32'(e.d));
        chk(acc_err == e.e, {e.tag, " err"}, 32'(acc_err), 32'(e.e));
      end
    end
  end

  task automatic do_read(input logic [4:0] a, input logic [15:0] d, input logic e,
                         input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    sb.push_back('{d, e, tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d, input logic e,
                          input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(acc_err == e, {tag, " write err"}, 32'(acc_err), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle valid after reset", 32'(rsp_valid), 32'd0);
    chk(acc_err == 1'b0, "R5 idle err after reset", 32'(acc_err), 32'd0);

    // R1 reset values
    do_read(5'd0,  16'h1140, 1'b0, "R1 ctrl");
    do_read(5'd1,  16'h794D, 1'b0, "R1 status");
    do_read(5'd2,  16'h0141, 1'b0, "R1 id1");
    do_read(5'd3,  ID2,      1'b0, "R1 id2");
    do_read(5'd4,  16'h0DE1, 1'b0, "R1 adv");
    do_read(5'd5,  16'h01E0, 1'b0, "R1 partner");
    do_read(5'd6,  16'h0000, 1'b0, "R1 expansion");
    do_read(5'd9,  16'h0E00, 1'b0, "R1 gig ctrl");
    do_read(5'd10, 16'h3C00, 1'b0, "R1 gig status");
    do_read(5'd16, 16'h0360, 1'b0, "R1 vendor ctrl");
    do_read(5'd17, 16'hAC00, 1'b0, "R1 vendor status");
    do_read(5'd20, 16'h0D60, 1'b0, "R1 ext ctrl");
    do_read(5'd21, 16'h0000, 1'b0, "R1 rx err");

    // R3 read-write storage
    do_write(5'd4,  16'hABCD, 1'b0, "R3 adv");
    do_write(5'd16, 16'h1234, 1'b0, "R3 vendor");
    do_write(5'd20, 16'hFFFF, 1'b0, "R3 ext");
    do_write(5'd9,  16'h0001, 1'b0, "R3 gig");
    do_read(5'd4,  16'hABCD, 1'b0, "R3 adv readback");
    do_read(5'd16, 16'h1234, 1'b0, "R3 vendor readback");
    do_read(5'd20, 16'hFFFF, 1'b0, "R3 ext readback");
    do_read(5'd9,  16'h0001, 1'b0, "R3 gig readback");

    // R5 writes to read-only and holes are ignored
    do_write(5'd2,  16'hFFFF, 1'b1, "R5 id1");
    do_write(5'd17, 16'h0000, 1'b1, "R5 vendor status");
    do_write(5'd1,  16'h0000, 1'b1, "R5 status");
    do_write(5'd7,  16'h5555, 1'b1, "R5 hole");
    do_read(5'd2,  16'h0141, 1'b0, "R5 id1 kept");
    do_read(5'd17, 16'hAC00, 1'b0, "R5 vendor status kept");
    do_read(5'd1,  16'h794D, 1'b0, "R5 status kept");

    // R6 hole reads
    do_read(5'd7,  16'h0000, 1'b1, "R6 hole 7");
    do_read(5'd31, 16'h0000, 1'b1, "R6 hole 31");

    // R4 and R7: full control write restarts auto-negotiation
    do_write(5'd0, 16'hFFFF, 1'b0, "R4 ctrl all ones");
    do_read(5'd0, 16'h7DC0, 1'b0, "R4 ctrl filtered");
    do_read(5'd1, 16'h7949, 1'b0, "R7 status cleared on restart");
    repeat (AN_CYC + 4) @(negedge clk);
    do_read(5'd1, 16'h796D, 1'b0, "R9 status after expiry");

    // R7 restart during a countdown starts it over
    do_write(5'd0, 16'h1200, 1'b0, "R7 restart a");
    repeat (AN_CYC - 6) @(negedge clk);
    do_write(5'd0, 16'h1200, 1'b0, "R7 restart b");
    repeat (AN_CYC - 6) @(negedge clk);
    do_read(5'd1, 16'h7949, 1'b0, "R7 second restart still counting");
    repeat (10) @(negedge clk);
    do_read(5'd1, 16'h796D, 1'b0, "R9 complete after second restart");

    // R8 restart without enable
    do_write(5'd0, 16'h0200, 1'b0, "R8 rerun without enable");
    do_read(5'd0, 16'h0000, 1'b0, "R8 ctrl value");
    do_read(5'd1, 16'h796D, 1'b0, "R8 status untouched");
    repeat (AN_CYC + 4) @(negedge clk);
    do_read(5'd1, 16'h796D, 1'b0, "R8 status still untouched");

    // R10 link low
    @(negedge clk);
    link_in = 1'b0;
    repeat (2) @(negedge clk);
    do_read(5'd1, 16'h7949, 1'b0, "R10 link low clears");
    do_write(5'd0, 16'h1200, 1'b0, "R10 restart while down");
    do_read(5'd0, 16'h1000, 1'b0, "R10 ctrl value");
    repeat (AN_CYC + 4) @(negedge clk);
    do_read(5'd1, 16'h7949, 1'b0, "R10 no completion while down");

    // R9 link back, restart completes
    @(negedge clk);
    link_in = 1'b1;
    repeat (2) @(negedge clk);
    do_read(5'd1, 16'h7949, 1'b0, "R10 bits stay clear until restart");
    do_write(5'd0, 16'h1200, 1'b0, "R9 restart with link");
    repeat (AN_CYC + 4) @(negedge clk);
    do_read(5'd1, 16'h796D, 1'b0, "R9 complete with link");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 all responses seen", 32'(sb.size()), 32'd0);
    chk(rsp_valid == 1'b0, "R2 valid low when idle", 32'(rsp_valid), 32'd0);
    finish_up();
  end
endmodule